// File: doc/BRIEF.md
# GPIO Level Alarm Monitor

This block watches a GPIO input port of up to 32 bits on behalf of a configurable number of clients. Each client owns two masks. Its high-alarm mask names pins whose high level should wake it, and its low-alarm mask names pins whose low level should wake it. Whenever an evaluation happens, the block computes per client whether any watched pin sits at its alarm level. The result drives a per-client wake flag. An evaluation happens on a periodic tick input or when one of the block's own pin interrupts fires.

The lowest pins of the port (eight by default) also act as high-level interrupt sources. On each tick the block enables a source only for a pin that is currently low and that some client watches for a high level. A source fires when its synchronized pin is high while it is enabled. Firing disables that source, pulses an interrupt output for one cycle and triggers an evaluation. In this way a pin that is already high does not raise an interrupt storm.

Clients arm and clear their masks through a single command port, which also reads them back. Pins pass through a two-flop synchronizer before any comparison.

Top module: `gpio_alarm_mon`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `wake`, `irq_en`, `irq_out`, `any_alarm`, `rd_high` and `rd_low` are all zero.
- R2: A command with `cmd_op` = 2'b00 ORs `cmd_arg` into the high mask of client `cmd_client`; the other clients' masks are unchanged.
- R3: A command with `cmd_op` = 2'b01 ORs `cmd_arg` into the low mask of client `cmd_client`.
- R4: A command with `cmd_op` = 2'b10 clears the `cmd_arg` bits from both masks of client `cmd_client`.
- R5: A command with `cmd_op` = 2'b11 loads `rd_high`/`rd_low` at the next edge with the selected client's masks as they stood before that edge; the outputs hold otherwise.
- R6: `any_alarm` equals, one cycle late, the OR of every bit of every client's two masks; it falls once all masks are zero.
- R7: On an evaluation (tick high, or any source firing), `wake[c]` becomes 1 when (pins AND high mask) OR (NOT pins AND low mask) is nonzero for client c, using the pins after two synchronizing flops, and 0 otherwise; between evaluations it holds.
- R8: `wake` is all zero in the cycle after `any_alarm` is low.
- R9: On a tick, `irq_en` gains the bits of the low IRQ_W synchronized pins that are low and set in any client's high mask; pins at or above IRQ_W never enable.
- R10: A source fires when its synchronized pin is high and its `irq_en` bit is set; at the next edge that bit clears and `irq_out` is high for one cycle, and the fire counts as an evaluation for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | DATA_W | Asynchronous GPIO levels |
| tick | input | 1 | Periodic re-evaluation strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 arm high, 01 arm low, 10 clear, 11 read |
| cmd_client | input | CW | Target client index |
| cmd_arg | input | DATA_W | Pin mask argument |
| rd_high | output | DATA_W | Read-back high mask |
| rd_low | output | DATA_W | Read-back low mask |
| any_alarm | output | 1 | Some client has a nonzero mask |
| irq_en | output | IRQ_W | Enabled high-level interrupt sources |
| irq_out | output | 1 | One-cycle pulse when a source fires |
| wake | output | N_CLIENTS | Per-client wake flag |

## Verification
On every cycle the assertions check these properties: masks never move without a command, the any-alarm flag tracks the previous masks, wake is forced low after the flag drops, a source is newly enabled only after a tick, and a fired source is gone at the next edge. Which pins a tick enables, and what value each wake takes at an evaluation, depend on pin history and on all clients' masks together. The bench's behavioural model shows these, both in directed sequences (arm, tick, pin rise, clear-all) and in a long stretch of random commands, pins and ticks.

// File: rtl/gam_pkg.sv
package gam_pkg;
  typedef enum logic [1:0] {
    OP_ARM_HIGH = 2'b00,
    OP_ARM_LOW  = 2'b01,
    OP_CLEAR    = 2'b10,
    OP_READ     = 2'b11
  } gam_op_e;
endpackage

// File: rtl/gam_sync.sv
module gam_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gam_client_bank.sv
module gam_client_bank
  import gam_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  gam_op_e             cmd_op,
  input  logic [CW-1:0]       cmd_client,
  input  logic [W-1:0]        cmd_arg,
  output logic [N-1:0][W-1:0] hi_q,
  output logic [N-1:0][W-1:0] lo_q,
  output logic [W-1:0]        rd_high,
  output logic [W-1:0]        rd_low
);
  for (genvar c = 0; c < N; c++) begin : g_client
    logic hit;
    assign hit = cmd_valid && (cmd_client == CW'(c));
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q[c] <= '0;
        lo_q[c] <= '0;
      end else if (hit) begin
        case (cmd_op)
          OP_ARM_HIGH: hi_q[c] <= hi_q[c] | cmd_arg;
          OP_ARM_LOW:  lo_q[c] <= lo_q[c] | cmd_arg;
          OP_CLEAR: begin
            hi_q[c] <= hi_q[c] & ~cmd_arg;
            lo_q[c] <= lo_q[c] & ~cmd_arg;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_high <= '0;
      rd_low  <= '0;
    end else if (cmd_valid && cmd_op == OP_READ) begin
      if (int'(cmd_client) < N) begin
        rd_high <= hi_q[cmd_client];
        rd_low  <= lo_q[cmd_client];
      end else begin
        rd_high <= '0;
        rd_low  <= '0;
      end
    end
  end
endmodule

// File: rtl/gam_irq_ctrl.sv
module gam_irq_ctrl #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [IW-1:0] pins,
  input  logic [IW-1:0] hi_any,
  output logic [IW-1:0] en_q,
  output logic [IW-1:0] fired,
  output logic          irq_q
);
  logic [IW-1:0] arm_set;
  assign fired   = pins & en_q;
  assign arm_set = tick ? (~pins & hi_any) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= (en_q & ~fired) | arm_set;
      irq_q <= |fired;
    end
  end
endmodule

// File: rtl/gam_wake_eval.sv
module gam_wake_eval #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                eval,
  input  logic                any_alarm,
  input  logic [W-1:0]        pins,
  input  logic [N-1:0][W-1:0] hi_q,
  input  logic [N-1:0][W-1:0] lo_q,
  output logic [N-1:0]        wake_q
);
  for (genvar c = 0; c < N; c++) begin : g_eval
    logic cond;
    assign cond = |((pins & hi_q[c]) | (~pins & lo_q[c]));
    always_ff @(posedge clk) begin
      if (rst || !any_alarm) wake_q[c] <= 1'b0;
      else if (eval)         wake_q[c] <= cond;
    end
  end
endmodule

// File: rtl/gpio_alarm_mon.sv
module gpio_alarm_mon
  import gam_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IRQ_W     = 8,
  parameter int N_CLIENTS = 4,
  localparam int CW = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    pins_in,
  input  logic                 tick,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [CW-1:0]        cmd_client,
  input  logic [DATA_W-1:0]    cmd_arg,
  output logic [DATA_W-1:0]    rd_high,
  output logic [DATA_W-1:0]    rd_low,
  output logic                 any_alarm,
  output logic [IRQ_W-1:0]     irq_en,
  output logic                 irq_out,
  output logic [N_CLIENTS-1:0] wake
);
  logic [DATA_W-1:0]                 data_s;
  logic [N_CLIENTS-1:0][DATA_W-1:0]  hi_q, lo_q;
  logic [DATA_W-1:0]                 hi_or, lo_or;
  logic [IRQ_W-1:0]                  fired;
  logic                              any_q;

  gam_sync #(.W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(data_s)
  );

  gam_client_bank #(.W(DATA_W), .N(N_CLIENTS), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(gam_op_e'(cmd_op)),
    .cmd_client(cmd_client), .cmd_arg(cmd_arg), .hi_q(hi_q), .lo_q(lo_q),
    .rd_high(rd_high), .rd_low(rd_low)
  );

  always_comb begin
    hi_or = '0;
    lo_or = '0;
    for (int c = 0; c < N_CLIENTS; c++) begin
      hi_or = hi_or | hi_q[c];
      lo_or = lo_or | lo_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |(hi_or | lo_or);
  end

  gam_irq_ctrl #(.IW(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .tick(tick), .pins(data_s[IRQ_W-1:0]),
    .hi_any(hi_or[IRQ_W-1:0]), .en_q(irq_en), .fired(fired), .irq_q(irq_out)
  );

  gam_wake_eval #(.W(DATA_W), .N(N_CLIENTS)) u_wake (
    .clk(clk), .rst(rst), .eval(tick | (|fired)), .any_alarm(any_q),
    .pins(data_s), .hi_q(hi_q), .lo_q(lo_q), .wake_q(wake)
  );

  assign any_alarm = any_q;
endmodule

// File: rtl/gpio_alarm_mon_chk.sv
module gpio_alarm_mon_chk #(
  parameter int DATA_W    = 32,
  parameter int IRQ_W     = 8,
  parameter int N_CLIENTS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick,
  input logic                        cmd_valid,
  input logic [DATA_W-1:0]           data_s,
  input logic [N_CLIENTS*DATA_W-1:0] hi_v,
  input logic [N_CLIENTS*DATA_W-1:0] lo_v,
  input logic                        any_alarm,
  input logic [IRQ_W-1:0]            irq_en,
  input logic [N_CLIENTS-1:0]        wake
);
  // R2 R3 R4: masks only move under a command
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_valid) |-> ($stable(hi_v) && $stable(lo_v)));

  assert_any_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    (|($past(hi_v) | $past(lo_v))) == any_alarm);

  assert_wake_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !any_alarm |=> (wake == '0));

  assert_enable_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (|(irq_en & ~$past(irq_en))) |-> $past(tick));

  assert_fired_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_en & $past(irq_en & data_s[IRQ_W-1:0])) == '0);
endmodule

bind gpio_alarm_mon gpio_alarm_mon_chk #(
  .DATA_W(DATA_W), .IRQ_W(IRQ_W), .N_CLIENTS(N_CLIENTS)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .data_s(data_s),
  .hi_v(hi_q), .lo_v(lo_q), .any_alarm(any_alarm), .irq_en(irq_en), .wake(wake)
);

// File: tb/gpio_alarm_mon_test.sv
module gpio_alarm_mon_test;
  localparam int W = 32, IW = 8, N = 4;

  logic clk = 0, rst = 1;
  logic [W-1:0] pins_in = '0, cmd_arg = '0;
  logic tick = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 2'b00, cmd_client = 2'b00;
  logic [W-1:0] rd_high, rd_low;
  logic any_alarm, irq_out;
  logic [IW-1:0] irq_en;
  logic [N-1:0] wake;

  always #10 clk = ~clk;

  gpio_alarm_mon uut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_client(cmd_client), .cmd_arg(cmd_arg),
    .rd_high(rd_high), .rd_low(rd_low), .any_alarm(any_alarm),
    .irq_en(irq_en), .irq_out(irq_out), .wake(wake)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_s1, m_s2, m_hi[N], m_lo[N], m_rdh, m_rdl;
  logic [IW-1:0] m_en;
  logic m_any, m_irq;
  logic [N-1:0] m_wake;

  always @(posedge clk) begin
    logic [IW-1:0] f, add;
    logic [W-1:0] ha, la;
    logic [N-1:0] nw;
    logic na, ev;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_en = '0; m_any = 0; m_irq = 0; m_wake = '0;
      m_rdh = '0; m_rdl = '0;
      for (int c = 0; c < N; c++) begin m_hi[c] = '0; m_lo[c] = '0; end
    end else begin
      ha = '0; la = '0;
      for (int c = 0; c < N; c++) begin ha |= m_hi[c]; la |= m_lo[c]; end
      f = m_s2[IW-1:0] & m_en;
      ev = tick || (f != 0);
      for (int c = 0; c < N; c++)
        nw[c] = !m_any ? 1'b0 :
                ev ? (((m_s2 & m_hi[c]) | (~m_s2 & m_lo[c])) != 0) : m_wake[c];
      add = tick ? (~m_s2[IW-1:0] & ha[IW-1:0]) : '0;
      na = ((ha | la) != 0);
      if (cmd_valid) begin
        case (cmd_op)
          2'b00: m_hi[cmd_client] |= cmd_arg;
          2'b01: m_lo[cmd_client] |= cmd_arg;
          2'b10: begin m_hi[cmd_client] &= ~cmd_arg; m_lo[cmd_client] &= ~cmd_arg; end
          default: begin m_rdh = m_hi[cmd_client]; m_rdl = m_lo[cmd_client]; end
        endcase
      end
      m_en = (m_en & ~f) | add;
      m_irq = (f != 0);
      m_wake = nw;
      m_any = na;
      m_s2 = m_s1;
      m_s1 = pins_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 wake model", W'(wake), W'(m_wake));
      chk("R9 irq_en model", W'(irq_en), W'(m_en));
      chk("R10 irq_out model", W'(irq_out), W'(m_irq));
      chk("R6 any_alarm model", W'(any_alarm), W'(m_any));
      chk("R5 rd_high model", rd_high, m_rdh);
      chk("R5 rd_low model", rd_low, m_rdl);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic [1:0] op, logic [1:0] cl, logic [W-1:0] arg);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_client = cl; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    idle(3);
    chk("R1 reset wake", W'(wake), '0);
    chk("R1 reset irq_en", W'(irq_en), '0);
    chk("R1 reset rd", rd_high | rd_low, '0);
    chk("R1 reset any", W'({any_alarm, irq_out}), '0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", W'({any_alarm, irq_out, irq_en, wake}), '0);

    cmd(2'b00, 2'd0, 32'h0000_0003);
    cmd(2'b01, 2'd1, 32'h0001_0000);
    cmd(2'b00, 2'd0, 32'h0000_0010);
    cmd(2'b11, 2'd0, '0);
    chk("R2 high mask OR", rd_high, 32'h13);
    cmd(2'b11, 2'd1, '0);
    chk("R3 low mask", rd_low, 32'h0001_0000);
    chk("R2 other client untouched", rd_high, 32'h0);
    chk("R6 any set", W'(any_alarm), 1);

    pulse_tick();
    idle(1);
    chk("R9 tick enables low pins", W'(irq_en), 32'h13);
    chk("R7 wake low alarm", W'(wake), 32'h2);

    @(negedge clk); pins_in = 32'h1;
    idle(5);
    chk("R10 fired source cleared", W'(irq_en), 32'h12);
    chk("R10 fire evaluates wake", W'(wake), 32'h3);

    cmd(2'b00, 2'd2, 32'h0000_0100);
    pulse_tick();
    idle(1);
    chk("R9 pin above IRQ_W never enabled", W'(irq_en), 32'h12);

    cmd(2'b10, 2'd1, 32'h0001_0000);
    cmd(2'b11, 2'd1, '0);
    chk("R4 clear low", rd_low, 32'h0);
    cmd(2'b10, 2'd0, 32'hFFFF_FFFF);
    cmd(2'b10, 2'd2, 32'hFFFF_FFFF);
    idle(2);
    chk("R6 any drops", W'(any_alarm), 0);
    chk("R8 wake forced low", W'(wake), 0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom % 3) == 0;
      cmd_op = 2'($urandom);
      cmd_client = 2'($urandom);
      cmd_arg = $urandom & $urandom;
      tick = ($urandom % 7) == 0;
      if (($urandom % 4) == 0) pins_in = $urandom;
    end
    @(negedge clk);
    cmd_valid = 0; tick = 0;
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog (all) actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule